// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller turns single internal requests (a code fetch, a data read or a data write) into bus cycles on an 8-bit multiplexed external memory bus. Each external cycle drives an address-latch strobe, an upper address port, a shared low port and an optional 18th address line. Code fetches may instead be served from an on-chip ROM. The choice depends on a strap pin that is captured while reset is held.

Two port mappings are available. In non-page mode the low port carries the low address byte and then the data byte. In page mode the low port holds the low address for the whole cycle, and the upper port carries first the high address byte and then the data. The mode bit and the region bits are taken from the configuration inputs only when a request is accepted. They therefore never change a cycle that is already running.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While `rst_n` is low (synchronous reset), the block shows busy=0, done=0, ale=0, rd_n=1, wr_n=1, ad_oe=0, a_hi_oe=0, rom_en=0 and a17_en=0 from the first clock edge onward.
- R2: A request is accepted on a clock edge where `req` is high and the block is idle. An off-chip access then spends exactly one cycle in each of three states: address, latch and data. busy is high in all three. done pulses for one cycle in the cycle after the data state, and busy is low in that same cycle.
- R3: ale is high only in the address state, for exactly one cycle. In the address state and in the latch state, the bus drives the address with both ports enabled: ad_out holds bits 7:0 and a_hi_out holds bits 15:8.
- R4: ext_acc_strap is captured on every clock edge while reset is low. A change on the pin after reset has no effect until the next reset.
- R5: When the captured strap is 0, every access goes off-chip, including code fetches at address 0.
- R6: When the captured strap is 1, a code fetch whose 18-bit address is below ROM_BYTES is served on-chip. rom_en is high for one cycle, with rom_addr equal to address bits 15:0. done and rdata=rom_rdata follow in the next cycle, and ale is never raised. All other code fetches, and all data accesses, go off-chip.
- R7: In non-page mode (cfg_page=0), the data state keeps a_hi_out driven with address bits 15:8. The low port carries write data with ad_oe=1, or is released with ad_oe=0 for a read, in which case rdata is taken from ad_in.
- R8: In page mode (cfg_page=1), the data state keeps ad_out driven with address bits 7:0. The upper port carries write data with a_hi_oe=1, or is released with a_hi_oe=0 for a read, in which case rdata is taken from a_hi_in.
- R9: The extended arrangement is selected when cfg_region equals 2'b00. In that case a17_en=1 and a17_out equals address bit 17 of the accepted request. Otherwise a17_en=0 and a17_out=0.
- R10: In a read, rd_n is low only in the data state. The read byte is sampled at the end of that state and is presented on rdata together with done.
- R11: In a write, wr_n is low only in the data state. rd_n and wr_n are never low together.
- R12: cfg_page and cfg_region are sampled only when a request is accepted. Changing them during a cycle does not alter that cycle's mapping or a17 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_acc_strap | input | 1 | External-access strap, captured during reset |
| cfg_page | input | 1 | Page-mode select |
| cfg_region | input | 2 | Region-decode bits; 2'b00 selects the 18-bit bus |
| req | input | 1 | Access request |
| req_code | input | 1 | Request is a code fetch |
| req_wr | input | 1 | Request is a write |
| req_addr | input | 18 | Request address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read result |
| rom_en | output | 1 | On-chip ROM read strobe |
| rom_addr | output | 16 | On-chip ROM address |
| rom_rdata | input | 8 | On-chip ROM data |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | External read strobe |
| wr_n | output | 1 | External write strobe |
| a_hi_out | output | 8 | Upper port output value |
| a_hi_oe | output | 1 | Upper port output enable |
| a_hi_in | input | 8 | Upper port input value |
| ad_out | output | 8 | Low port output value |
| ad_oe | output | 1 | Low port output enable |
| ad_in | input | 8 | Low port input value |
| a17_out | output | 1 | Address bit 17 |
| a17_en | output | 1 | Address bit 17 owns its pin |

## Verification
A faulty state sequence shows up within one cycle of the error as an ale pulse in the wrong cycle, a missing or late done, or busy staying high. A wrongly latched mode bit or strap only becomes visible at the first data state or code fetch that depends on it. At that point it appears as the wrong port driving or released, as rdata taken from the wrong port, or as ale appearing where the on-chip ROM should have answered. The bench therefore checks every port in every phase of each access, and it changes the configuration inputs in the middle of cycles.

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
  parameter int ROM_BYTES = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_acc_strap,
  input  logic        cfg_page,
  input  logic [1:0]  cfg_region,
  input  logic        req,
  input  logic        req_code,
  input  logic        req_wr,
  input  logic [17:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        rom_en,
  output logic [15:0] rom_addr,
  input  logic [7:0]  rom_rdata,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  a_hi_out,
  output logic        a_hi_oe,
  input  logic [7:0]  a_hi_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic        a17_out,
  output logic        a17_en
);

  localparam logic [18:0] ROM_LIM = 19'(ROM_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LATCH, S_DATA, S_ROM} st_t;

  st_t         state;
  logic        ea_q, page_q, ext_q, wr_q;
  logic [17:0] addr_q;
  logic [7:0]  wdata_q;

  wire accept  = req && (state == S_IDLE);
  wire on_chip = req_code && ea_q && ({1'b0, req_addr} < ROM_LIM);
  wire addr_ph = (state == S_ADDR) || (state == S_LATCH);
  wire data_ph = (state == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q    <= ext_acc_strap;
      state   <= S_IDLE;
      page_q  <= 1'b0;
      ext_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state   <= on_chip ? S_ROM : S_ADDR;
          page_q  <= cfg_page;
          ext_q   <= (cfg_region == 2'b00);
          wr_q    <= req_wr && !req_code;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        S_ADDR:  state <= S_LATCH;
        S_LATCH: state <= S_DATA;
        S_DATA: begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (!wr_q) rdata <= page_q ? a_hi_in : ad_in;
        end
        S_ROM: begin
          state <= S_IDLE;
          done  <= 1'b1;
          rdata <= rom_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign ale      = (state == S_ADDR);
  assign rom_en   = (state == S_ROM);
  assign rom_addr = addr_q[15:0];
  assign rd_n     = !(data_ph && !wr_q);
  assign wr_n     = !(data_ph && wr_q);
  assign ad_oe    = addr_ph || (data_ph && (page_q || wr_q));
  assign ad_out   = (data_ph && !page_q) ? wdata_q : addr_q[7:0];
  assign a_hi_oe  = addr_ph || (data_ph && (!page_q || wr_q));
  assign a_hi_out = (data_ph && page_q) ? wdata_q : addr_q[15:8];
  assign a17_en   = ext_q;
  assign a17_out  = ext_q & addr_q[17];

  AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R3
  AST_ALE_DRIVES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && a_hi_oe)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ($stable(ad_out) && $stable(a_hi_out))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ea_q)); // R4
  AST_ROM_NO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (!ale && rd_n && wr_n)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R11
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(a17_en)); // R12
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !(ad_oe && a_hi_oe)); // R10

endmodule

// File: tb/tb_xmem_bus_ctrl.sv
module tb_xmem_bus_ctrl;
  localparam int ROM_BYTES = 16384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_acc_strap = 1'b1;
  logic cfg_page = 1'b0;
  logic [1:0] cfg_region = 2'b01;
  logic req = 1'b0, req_code = 1'b0, req_wr = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic busy, done, rom_en, ale, rd_n, wr_n, a_hi_oe, ad_oe, a17_out, a17_en;
  logic [7:0] rdata, rom_rdata, a_hi_out, a_hi_in, ad_out, ad_in;
  logic [15:0] rom_addr;
  logic [15:0] cap = '0;

  int tests = 0, fails = 0;
  bit strap_exp = 1'b1;

  always #2 clk = ~clk;

  xmem_bus_ctrl #(.ROM_BYTES(ROM_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .ext_acc_strap(ext_acc_strap),
    .cfg_page(cfg_page), .cfg_region(cfg_region),
    .req(req), .req_code(req_code), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .a_hi_out(a_hi_out), .a_hi_oe(a_hi_oe), .a_hi_in(a_hi_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .a17_out(a17_out), .a17_en(a17_en)
  );

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return (a[7:0] + 8'h33) ^ {a[11:8], a[15:12]};
  endfunction

  assign rom_rdata = rom_fn(rom_addr);
  always @(negedge clk) if (ale) cap <= {a_hi_out, ad_out};
  assign ad_in   = mem_fn(cap);
  assign a_hi_in = ~mem_fn(cap);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 1'b0;
    ext_acc_strap = strap;
    strap_exp = strap;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !ale && rd_n && wr_n && !ad_oe && !a_hi_oe && !rom_en && !a17_en,
        "R1 reset outputs", {busy, done, ale, rd_n, wr_n, ad_oe, a_hi_oe, rom_en, a17_en}, 9'b000110000);
    rst_n = 1'b1;
  endtask

  task automatic txn(input bit code, input bit wr, input logic [17:0] a, input logic [7:0] wd, input bit flip);
    bit pg = cfg_page;
    bit ex = (cfg_region == 2'b00);
    bit wrx = wr && !code;
    bit on = code && strap_exp && (a < 18'(ROM_BYTES));
    logic [7:0] exp_rd;
    req = 1'b1; req_code = code; req_wr = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    if (flip) begin cfg_page = ~cfg_page; cfg_region = ~cfg_region; end
    if (on) begin
      chk(rom_en && !ale && busy, "R6 on-chip strobe", {rom_en, ale, busy}, 3'b101);
      chk(rom_addr == a[15:0], "R6 rom_addr", rom_addr, a[15:0]);
      @(negedge clk);
      chk(done && !busy && rdata == rom_fn(a[15:0]), "R6 rom data", {done, busy, rdata}, {2'b10, rom_fn(a[15:0])});
      return;
    end
    chk(ale && busy && !rom_en, "R2 R5 address state", {ale, busy, rom_en}, 3'b110);
    chk(ad_oe && a_hi_oe && ad_out == a[7:0] && a_hi_out == a[15:8], "R3 address on ports",
        {ad_oe, a_hi_oe, a_hi_out, ad_out}, {2'b11, a[15:0]});
    chk(a17_en == ex && a17_out == (ex & a[17]), "R9 a17", {a17_en, a17_out}, {ex, ex & a[17]});
    @(negedge clk);
    chk(!ale && busy && ad_oe && a_hi_oe && ad_out == a[7:0] && a_hi_out == a[15:8], "R3 latch hold",
        {ale, busy, a_hi_out, ad_out}, {2'b01, a[15:0]});
    @(negedge clk);
    chk(!ale && busy && rd_n == wrx && wr_n == !wrx, "R10 R11 strobes", {ale, busy, rd_n, wr_n}, {2'b01, wrx, !wrx});
    chk(a17_en == ex, "R12 a17 kept", a17_en, ex);
    if (!pg) begin
      chk(a_hi_oe && a_hi_out == a[15:8] && ad_oe == wrx && (!wrx || ad_out == wd),
          "R7 R12 non-page data", {a_hi_oe, ad_oe, a_hi_out, ad_out}, {1'b1, wrx, a[15:8], wd});
    end else begin
      chk(ad_oe && ad_out == a[7:0] && a_hi_oe == wrx && (!wrx || a_hi_out == wd),
          "R8 R12 page data", {ad_oe, a_hi_oe, ad_out, a_hi_out}, {1'b1, wrx, a[7:0], wd});
    end
    @(negedge clk);
    exp_rd = pg ? ~mem_fn(a[15:0]) : mem_fn(a[15:0]);
    chk(done && !busy && rd_n && wr_n, "R2 done pulse", {done, busy, rd_n, wr_n}, 4'b1011);
    if (!wrx) chk(rdata == exp_rd, "R10 read data", rdata, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset(1'b1);
    txn(1, 0, 18'd0, 8'h00, 0);
    txn(1, 0, 18'(ROM_BYTES - 1), 8'h00, 0);
    txn(1, 0, 18'(ROM_BYTES), 8'h00, 0);
    txn(0, 0, 18'h00005, 8'h00, 0);
    txn(0, 1, 18'h012A5, 8'hC3, 0);
    cfg_page = 1'b1;
    txn(0, 0, 18'h0BEEF, 8'h00, 0);
    txn(0, 1, 18'h04321, 8'h9E, 0);
    cfg_region = 2'b00;
    txn(0, 0, 18'h2F00D, 8'h00, 1);
    txn(0, 1, 18'h3A55A, 8'h7C, 1);
    txn(1, 0, 18'h20010, 8'h00, 0);
    ext_acc_strap = 1'b0;
    txn(1, 0, 18'd10, 8'h00, 0);
    for (int i = 0; i < 120; i++) begin
      logic [17:0] a = ($urandom % 2) ? 18'($urandom % 32768) : 18'($urandom);
      cfg_page = $urandom;
      cfg_region = $urandom;
      txn($urandom, $urandom, a, 8'($urandom), $urandom);
    end
    do_reset(1'b0);
    txn(1, 0, 18'd10, 8'h00, 0);
    ext_acc_strap = 1'b1;
    txn(1, 0, 18'd0, 8'h00, 0);
    for (int i = 0; i < 60; i++) begin
      logic [17:0] a = 18'($urandom % 32768);
      cfg_page = $urandom;
      cfg_region = $urandom;
      txn($urandom, $urandom, a, 8'($urandom), $urandom);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule